// File: doc/BRIEF.md
# Host Controller Status and Interrupt Register

This block keeps the status word of a USB host controller. Event pulses from the transfer engine, the root ports, the bus master and the frame counter set six sticky interrupt flags. Software clears a flag by writing a one to its bit. A masked OR of the flags drives a registered interrupt line. The same word also reports whether the controller has halted, whether the asynchronous schedule is empty, and the actual state of the periodic and asynchronous schedules.

Three small machines sit beside the flag register. The run tracker follows the Run/Stop command and reports halted only after the controller confirms that it has stopped. A system error pulses an output that forces Run/Stop to clear. Each schedule tracker copies its enable bit into the status word only after the enable has held a new value for a programmable number of clocks. This stands in for the time the schedule takes to really start or stop. An advance doorbell arms a one-shot, and the next asynchronous advance turns it into a flag.

Run tracker states:
- ACTIVE: Run/Stop is high.
- DRAINING: Run/Stop has dropped and the controller has not yet confirmed that it stopped.
- HALTED: the controller has stopped.

Run tracker transitions:
- HALTED to ACTIVE when Run/Stop rises.
- ACTIVE to DRAINING when Run/Stop falls.
- DRAINING to HALTED when the stopped indication arrives.
- DRAINING to ACTIVE when Run/Stop rises again.

Schedule tracker states:
- SETTLED: the status equals the enable.
- SWITCHING: the enable differs from the status and the delay is counting.

Schedule tracker transitions:
- SETTLED to SWITCHING when the enable differs from the status.
- SWITCHING to SETTLED when the count completes, which updates the status.
- SWITCHING to SETTLED when the enable reverts, which leaves the status unchanged.

Top module: `host_status_reg`

## Requirements
- R1: After reset the read word is 16'h1000 when `async_empty` is 0. Flags 0 to 5 and both schedule status bits are 0, and the halted bit (bit 12) is 1.
- R2: Bit 0 sets on a `td_retire` pulse that has `td_ioc` or `td_short` high. A retire pulse with neither qualifier, or a qualifier without a retire pulse, sets nothing.
- R3: Bit 1 sets on a `td_retire` pulse with `td_error` high. If `td_ioc` is also high, bits 0 and 1 both set on the same edge.
- R4: Bit 2 sets on a `port_change` pulse.
- R5: Bit 3 sets when frame index bit (13 - `list_size`) changes between consecutive clocks. The encodings are 0 for 1024 entries, 1 for 512, 2 for 256 and 3 for 128. A change of any other index bit sets nothing.
- R6: Bit 4 sets on a `sys_err` pulse. `force_stop` is high for exactly the one cycle after that pulse.
- R7: Bit 5 sets on the first `async_advance` pulse that comes strictly after a `doorbell` pulse. An advance without a pending doorbell, or in the same cycle as the doorbell, sets nothing.
- R8: A write with `wr_en` high clears each of bits 0 to 5 where `wr_data` has a one. Writes to bits 6 to 15 have no effect. A hardware set in the same cycle as a clear leaves the flag at 1.
- R9: `irq` is the OR over bits 0 to 5 of (flag AND `irq_en`), delayed by one register. It rises one cycle after the flag becomes visible.
- R10: Bit 12 (halted) is 0 whenever `run_cmd` is 1. After `run_cmd` falls, bit 12 becomes 1 only on the edge after a `hc_stopped` pulse seen while draining. A `hc_stopped` pulse while active is ignored.
- R11: Bits 14 and 15 take the value of `per_en` and `async_en` SCHED_DELAY (default 4) clocks after the enable changes. An enable that reverts before that leaves the status unchanged. Bit 13 equals `async_empty` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| td_retire | input | 1 | Descriptor retired this cycle |
| td_ioc | input | 1 | Retired descriptor asked for an interrupt on completion |
| td_short | input | 1 | Short packet received |
| td_error | input | 1 | Transaction ended in error |
| port_change | input | 1 | Qualified port change event |
| sys_err | input | 1 | Host system access error |
| async_advance | input | 1 | Asynchronous schedule advanced |
| doorbell | input | 1 | Software rang the advance doorbell |
| frindex | input | 14 | Frame index counter |
| list_size | input | 2 | Frame list size code |
| run_cmd | input | 1 | Run/Stop command bit |
| hc_stopped | input | 1 | Controller confirms that it has stopped |
| per_en | input | 1 | Periodic schedule enable |
| async_en | input | 1 | Asynchronous schedule enable |
| async_empty | input | 1 | Asynchronous schedule is empty |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write data, a one clears a flag |
| irq_en | input | 6 | Interrupt enable mask |
| rd_data | output | 16 | Status word |
| irq | output | 1 | Registered interrupt request |
| force_stop | output | 1 | Pulse that forces Run/Stop to clear |

## Verification
The hardest corner is a hardware set and a software clear landing on the same edge. The bench produces it by raising a retire event and a one-write to bit 0 in the same half cycle. A similar corner is the halted transition, which needs Run/Stop to fall in the same cycle as a stray stop confirmation. The bench shows that confirmation is ignored and that a second confirmation is needed once draining. For the schedule delay, the bench samples once on the clock just before the status bit may change and once on the clock where it must. It also drops an enable before the delay ends to show that nothing changes.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
    localparam int FLAG_N  = 6;
    localparam int B_INT   = 0;
    localparam int B_ERR   = 1;
    localparam int B_PORT  = 2;
    localparam int B_ROLL  = 3;
    localparam int B_SYS   = 4;
    localparam int B_ADV   = 5;
    localparam int B_HALT  = 12;
    localparam int B_RECL  = 13;
    localparam int B_PSS   = 14;
    localparam int B_ASS   = 15;

    typedef enum logic [1:0] {RUN_ACTIVE, RUN_DRAINING, RUN_HALTED} run_state_e;
    typedef enum logic {TRK_SETTLED, TRK_SWITCHING} trk_state_e;
endpackage

// File: rtl/hs_flags.sv
`timescale 1ns/1ps
module hs_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flags_q, flags_d;
    logic         irq_q;

    // set dominates clear
    always_comb flags_d = (flags_q & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            irq_q   <= |(flags_q & irq_en);
        end
    end

    assign flags = flags_q;
    assign irq   = irq_q;

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags_q[i]);
        a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
    end

    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_q & irq_en) == '0) |=> !irq_q);
endmodule

// File: rtl/hs_rollover.sv
`timescale 1ns/1ps
module hs_rollover #(
    parameter int IDX_W   = 14,
    parameter int SEL_W   = 2,
    parameter int TOP_BIT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] frindex,
    input  logic [SEL_W-1:0] sel,
    output logic             roll
);
    localparam int POS_W = $clog2(IDX_W);

    logic [IDX_W-1:0] prev_q;
    logic [POS_W-1:0] pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= frindex;
    end

    // larger size code selects a lower index bit
    always_comb begin
        pos  = POS_W'(TOP_BIT) - POS_W'(sel);
        roll = frindex[pos] ^ prev_q[pos];
    end

    a_r5_quiet_index: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(frindex) |-> !roll);
endmodule

// File: rtl/hs_run_fsm.sv
`timescale 1ns/1ps
module hs_run_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_cmd,
    input  logic hc_stopped,
    input  logic sys_err,
    output logic halted,
    output logic force_stop
);
    run_state_e state_q, state_d;
    logic       force_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RUN_HALTED;
            force_q <= 1'b0;
        end else begin
            state_q <= state_d;
            force_q <= sys_err;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED:   if (run_cmd) state_d = RUN_ACTIVE;
            RUN_ACTIVE:   if (!run_cmd) state_d = RUN_DRAINING;
            RUN_DRAINING: begin
                if (run_cmd)         state_d = RUN_ACTIVE;
                else if (hc_stopped) state_d = RUN_HALTED;
            end
            default:      state_d = RUN_HALTED;
        endcase
    end

    always_comb begin
        halted     = (state_q == RUN_HALTED) && !run_cmd;
        force_stop = force_q;
    end

    a_r10_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RUN_ACTIVE) |=> (state_q != RUN_HALTED));
    a_r6_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sys_err |=> force_stop);
endmodule

// File: rtl/hs_sched_track.sv
`timescale 1ns/1ps
module hs_sched_track
    import hs_pkg::*;
#(
    parameter int DELAY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic status
);
    localparam int CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    trk_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= TRK_SETTLED;
            cnt_q    <= '0;
            status_q <= 1'b0;
        end else begin
            unique case (state_q)
                TRK_SETTLED: begin
                    if (en != status_q) begin
                        if (DELAY <= 1) status_q <= en;
                        else begin
                            state_q <= TRK_SWITCHING;
                            cnt_q   <= CNT_W'(1);
                        end
                    end
                end
                TRK_SWITCHING: begin
                    if (en == status_q) begin
                        state_q <= TRK_SETTLED;
                        cnt_q   <= '0;
                    end else if (cnt_q == LAST) begin
                        status_q <= en;
                        state_q  <= TRK_SETTLED;
                        cnt_q    <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= TRK_SETTLED;
            endcase
        end
    end

    assign status = status_q;

    a_r11_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (en == status_q) |=> $stable(status_q));
    a_r11_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_SETTLED && DELAY > 1) |=> $stable(status_q));
endmodule

// File: rtl/host_status_reg.sv
`timescale 1ns/1ps
module host_status_reg
    import hs_pkg::*;
#(
    parameter int REG_W       = 16,
    parameter int IDX_W       = 14,
    parameter int SEL_W       = 2,
    parameter int TOP_BIT     = 13,
    parameter int SCHED_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             td_retire,
    input  logic             td_ioc,
    input  logic             td_short,
    input  logic             td_error,
    input  logic             port_change,
    input  logic             sys_err,
    input  logic             async_advance,
    input  logic             doorbell,
    input  logic [IDX_W-1:0] frindex,
    input  logic [SEL_W-1:0] list_size,
    input  logic             run_cmd,
    input  logic             hc_stopped,
    input  logic             per_en,
    input  logic             async_en,
    input  logic             async_empty,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] irq_en,
    output logic [REG_W-1:0] rd_data,
    output logic             irq,
    output logic             force_stop
);
    logic [FLAG_N-1:0] set_vec, clr_vec, flags;
    logic              roll, halted, armed_q;
    logic [1:0]        sched_en, sched_st;
    logic              unused_wr_hi;

    assign unused_wr_hi = ^wr_data[REG_W-1:FLAG_N];

    // doorbell one-shot: an advance in the doorbell cycle does not count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= doorbell | (armed_q & ~async_advance);
    end

    always_comb begin
        set_vec         = '0;
        set_vec[B_INT]  = td_retire & (td_ioc | td_short);
        set_vec[B_ERR]  = td_retire & td_error;
        set_vec[B_PORT] = port_change;
        set_vec[B_ROLL] = roll;
        set_vec[B_SYS]  = sys_err;
        set_vec[B_ADV]  = armed_q & async_advance;
        clr_vec         = wr_en ? wr_data[FLAG_N-1:0] : '0;
    end

    hs_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    hs_rollover #(.IDX_W(IDX_W), .SEL_W(SEL_W), .TOP_BIT(TOP_BIT)) u_roll (
        .clk(clk), .rst_n(rst_n), .frindex(frindex), .sel(list_size), .roll(roll)
    );

    hs_run_fsm u_run (
        .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .hc_stopped(hc_stopped),
        .sys_err(sys_err), .halted(halted), .force_stop(force_stop)
    );

    assign sched_en = {async_en, per_en};

    for (genvar s = 0; s < 2; s++) begin : g_sched
        hs_sched_track #(.DELAY(SCHED_DELAY)) u_trk (
            .clk(clk), .rst_n(rst_n), .en(sched_en[s]), .status(sched_st[s])
        );
    end

    always_comb begin
        rd_data               = '0;
        rd_data[FLAG_N-1:0]   = flags;
        rd_data[B_HALT]       = halted;
        rd_data[B_RECL]       = async_empty;
        rd_data[B_PSS]        = sched_st[0];
        rd_data[B_ASS]        = sched_st[1];
    end

    a_r7_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && async_advance && !doorbell) |=> !armed_q);
    a_r7_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !flags[B_ADV]) |=> !flags[B_ADV]);
    a_r10_run_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
        run_cmd |-> !rd_data[B_HALT]);
endmodule

// File: tb/host_status_reg_tb_top.sv
`timescale 1ns/1ps
module host_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        td_retire = 0, td_ioc = 0, td_short = 0, td_error = 0;
    logic        port_change = 0, sys_err = 0, async_advance = 0, doorbell = 0;
    logic [13:0] frindex = '0;
    logic [1:0]  list_size = '0;
    logic        run_cmd = 0, hc_stopped = 0, per_en = 0, async_en = 0, async_empty = 0;
    logic        wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [5:0]  irq_en = '0;
    logic [15:0] rd_data;
    logic        irq, force_stop;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    host_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .td_retire(td_retire), .td_ioc(td_ioc),
        .td_short(td_short), .td_error(td_error), .port_change(port_change),
        .sys_err(sys_err), .async_advance(async_advance), .doorbell(doorbell),
        .frindex(frindex), .list_size(list_size), .run_cmd(run_cmd),
        .hc_stopped(hc_stopped), .per_en(per_en), .async_en(async_en),
        .async_empty(async_empty), .wr_en(wr_en), .wr_data(wr_data),
        .irq_en(irq_en), .rd_data(rd_data), .irq(irq), .force_stop(force_stop)
    );

    // {retire, ioc, short, error, port, syserr, expected flags[5:0]}
    localparam logic [11:0] VEC [8] = '{
        {6'b110000, 6'b000001},
        {6'b101000, 6'b000001},
        {6'b100100, 6'b000010},
        {6'b110100, 6'b000011},
        {6'b100000, 6'b000000},
        {6'b011100, 6'b000000},
        {6'b000010, 6'b000100},
        {6'b000001, 6'b010000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr_en = 1'b1; wr_data = 16'h003F;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset word", rd_data, 16'h1000);
        chk("R1 reset irq", {15'b0, irq}, 16'h0);

        // vector table: R2 R3 R4 R6 event decoding
        for (int v = 0; v < 8; v++) begin
            {td_retire, td_ioc, td_short, td_error, port_change, sys_err} = VEC[v][11:6];
            tick();
            {td_retire, td_ioc, td_short, td_error, port_change, sys_err} = '0;
            chk($sformatf("R2/R3/R4 vector %0d", v), {10'b0, rd_data[5:0]}, {10'b0, VEC[v][5:0]});
            clear_all();
        end

        // R6 force_stop pulse
        sys_err = 1'b1; tick(); sys_err = 1'b0;
        chk("R6 force_stop high", {15'b0, force_stop}, 16'h1);
        tick();
        chk("R6 force_stop one cycle", {15'b0, force_stop}, 16'h0);
        chk("R6 flag bit4", {10'b0, rd_data[5:0]}, 16'h0010);
        clear_all();

        // R5 rollover
        list_size = 2'd0; frindex = 14'h2000; tick();
        chk("R5 bit13 toggle size 1024", {15'b0, rd_data[3]}, 16'h1);
        clear_all();
        list_size = 2'd1; frindex = 14'h3000; tick();
        chk("R5 bit12 toggle size 512", {15'b0, rd_data[3]}, 16'h1);
        clear_all();
        frindex = 14'h1000; tick(); tick();
        chk("R5 other bit ignored", {15'b0, rd_data[3]}, 16'h0);
        list_size = 2'd3; frindex = 14'h1400; tick();
        chk("R5 bit10 toggle size 128", {15'b0, rd_data[3]}, 16'h1);
        clear_all();

        // R7 doorbell
        async_advance = 1'b1; tick(); async_advance = 1'b0; tick();
        chk("R7 advance without doorbell", {15'b0, rd_data[5]}, 16'h0);
        doorbell = 1'b1; async_advance = 1'b1; tick();
        doorbell = 1'b0; async_advance = 1'b0; tick();
        chk("R7 same-cycle advance ignored", {15'b0, rd_data[5]}, 16'h0);
        async_advance = 1'b1; tick(); async_advance = 1'b0;
        chk("R7 advance after doorbell", {15'b0, rd_data[5]}, 16'h1);
        clear_all();
        async_advance = 1'b1; tick(); async_advance = 1'b0;
        chk("R7 one-shot consumed", {15'b0, rd_data[5]}, 16'h0);

        // R8 write semantics
        port_change = 1'b1; tick(); port_change = 1'b0;
        wr_en = 1'b1; wr_data = 16'hF000; tick(); wr_en = 1'b0;
        chk("R8 high-bit write ignored", rd_data, 16'h1004);
        td_retire = 1'b1; td_ioc = 1'b1; tick();
        td_ioc = 1'b0; td_retire = 1'b0;
        wr_en = 1'b1; wr_data = 16'h0001; td_retire = 1'b1; td_ioc = 1'b1; tick();
        wr_en = 1'b0; wr_data = '0; td_retire = 1'b0; td_ioc = 1'b0;
        chk("R8 set beats clear", {10'b0, rd_data[5:0]}, 16'h0005);
        wr_en = 1'b1; wr_data = 16'h0004; tick(); wr_en = 1'b0;
        chk("R8 selective clear", {10'b0, rd_data[5:0]}, 16'h0001);
        clear_all();

        // R9 interrupt
        irq_en = 6'h01;
        td_retire = 1'b1; td_error = 1'b1; tick(); td_retire = 1'b0; td_error = 1'b0;
        tick();
        chk("R9 masked flag no irq", {15'b0, irq}, 16'h0);
        td_retire = 1'b1; td_short = 1'b1; tick(); td_retire = 1'b0; td_short = 1'b0;
        chk("R9 irq registered delay", {15'b0, irq}, 16'h0);
        tick();
        chk("R9 irq asserted", {15'b0, irq}, 16'h1);
        clear_all();
        tick();
        chk("R9 irq drops after clear", {15'b0, irq}, 16'h0);
        irq_en = '0;

        // R10 halted tracking
        run_cmd = 1'b1; #1;
        chk("R10 run clears halted", {15'b0, rd_data[12]}, 16'h0);
        tick(); tick();
        run_cmd = 1'b0; hc_stopped = 1'b1; tick(); hc_stopped = 1'b0;
        chk("R10 stop while active ignored", {15'b0, rd_data[12]}, 16'h0);
        tick(); tick();
        chk("R10 draining not halted", {15'b0, rd_data[12]}, 16'h0);
        hc_stopped = 1'b1; tick(); hc_stopped = 1'b0;
        chk("R10 halted after stop", {15'b0, rd_data[12]}, 16'h1);

        // R11 schedule status lag
        per_en = 1'b1;
        repeat (3) tick();
        chk("R11 periodic before delay", {15'b0, rd_data[14]}, 16'h0);
        tick();
        chk("R11 periodic after delay", {15'b0, rd_data[14]}, 16'h1);
        async_en = 1'b1; tick(); tick(); async_en = 1'b0;
        repeat (6) tick();
        chk("R11 async revert no change", {15'b0, rd_data[15]}, 16'h0);
        async_en = 1'b1; repeat (4) tick();
        chk("R11 async after delay", {15'b0, rd_data[15]}, 16'h1);
        async_empty = 1'b1; #1;
        chk("R11 empty bit mirrors input", {15'b0, rd_data[13]}, 16'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule